// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Front End

This block is the bus-facing half of a byte-addressed serial EEPROM. It oversamples the two-wire clock and data lines with the system clock, finds START and STOP conditions, and shifts bytes in and out. It drives SDA only through an open-drain enable: a high `sda_oe` pulls the line low. A transfer opens with a device byte whose upper four bits are the fixed prefix 1010 and whose next three bits must equal the strap pins. The low bit selects the direction: 0 is write and 1 is read.

A write transfer carries two address bytes, high byte first, and then data bytes. Each accepted data byte goes to the page buffer controller as a single beat on a valid/ready pair. The controller must hold `wr_ready` high when it can take a byte. If `wr_ready` is low when a byte completes, that byte is refused with a NACK and no beat is issued, so back-pressure from the controller shows on the bus as a NACK. A STOP after at least one accepted byte raises `commit`, which starts the controller's write cycle. While the controller reports `busy_i`, the device byte is not acknowledged, so a master can poll until the write cycle has finished.

Reads fetch bytes through a plain address/data lookup (`rd_addr` to `rd_data`, combinational in the memory). Three forms are supported: a current-address read, a random read (a dummy write of the address followed by a repeated START), and a sequential read that runs over the whole array.

Top module: `eep_i2c_target`

## Requirements
- R1: START (SDA falls while SCL is high) begins a new device byte, and STOP (SDA rises while SCL is high) returns the block to idle. Either one, seen in the middle of a byte, discards that byte without side effects.
- R2: The device byte is acknowledged (sda_oe high during the ninth clock) only when bits 7:4 are 1010 and bits 3:1 equal strap_i. On a mismatch the block gives no ACK and ignores all traffic until the next START.
- R3: While busy_i is high, a matching device byte receives no ACK.
- R4: In a write, the high address byte comes first and the low address byte second, and each is acknowledged. The pointer becomes {high[4:0], low}. The upper three bits of the high byte are ignored.
- R5: Each data byte that completes while wr_ready is high produces one single-cycle wr_valid beat with wr_addr and wr_data, and receives an ACK. If wr_ready is low, the byte is NACKed, no beat is issued, and the rest of the transfer is ignored.
- R6: After each accepted write byte, only the low five pointer bits increment, wrapping inside the 32-byte page.
- R7: commit pulses for one cycle after a STOP that ends a transfer with at least one accepted data byte. An address-only (dummy) write gives no commit.
- R8: Read data is driven MSB first from the byte at the pointer. A random read is a dummy write of the address, then a repeated START and a read device byte.
- R9: A sequential read continues while the master ACKs and increments all 13 pointer bits, wrapping from 8191 to 0. On a master NACK the block releases SDA and waits for STOP.
- R10: A current-address read starts at the last accessed address plus one.
- R11: sda_oe is low after reset, and it changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Device address strap bits |
| busy_i | input | 1 | Write cycle in progress; blocks the device ACK |
| wr_valid | output | 1 | Write beat valid (one cycle) |
| wr_ready | input | 1 | Buffer controller can take a byte |
| wr_addr | output | 13 | Memory address of the write beat |
| wr_data | output | 8 | Data of the write beat |
| commit | output | 1 | Start write cycle (one-cycle pulse after STOP) |
| rd_addr | output | 13 | Current pointer, used as the read address |
| rd_data | input | 8 | Byte at rd_addr |

## Verification
Two events share a single SCL rising edge: the pointer increment at the end of a read byte and the sampling of the master's ACK or NACK. If the pointer sits at 8191, that edge also wraps it to 0. The bench provokes this by ending a sequential read with a NACK on a byte near the top of the array. It judges the result by the following current-address read, which must return the byte after the wrap. A second overlap is a repeated START or a STOP arriving in the middle of a byte. The bench checks that no write beat, commit or pointer change leaks out of the aborted byte.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_RDATA,
    PH_HOLD
  } phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int unsigned AW = 13,
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_page,
  input  logic          step_full,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_page) ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
    else if (step_full) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_i2c_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int unsigned HI_W = ADDR_W - BITS_PER_BYTE;
  localparam logic [3:0]  LAST_BIT = 4'd8;

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  phase_e phase, nxt;
  logic [3:0] cnt;
  logic [7:0] shift, tx;
  logic [HI_W-1:0] hi_q;
  logic wrote;
  logic [ADDR_W-1:0] ptr;
  logic dev_match, byte_end_fall, ninth_rise;
  logic ptr_load, ptr_step_page, ptr_step_full;

  eep_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_end_fall = scl_fall && (cnt == LAST_BIT);
  assign ninth_rise    = scl_rise && (cnt == LAST_BIT);
  assign dev_match     = (shift[7:4] == DEV_PREFIX) && (shift[3:1] == strap_i) && !busy_i;
  assign ptr_load      = byte_end_fall && (phase == PH_ALO);
  assign ptr_step_page = byte_end_fall && (phase == PH_WDATA) && wr_ready;
  assign ptr_step_full = ninth_rise && (phase == PH_RDATA);

  eep_addr_ptr #(.AW(ADDR_W), .PW(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .load_val({hi_q, shift}),
    .step_page(ptr_step_page), .step_full(ptr_step_full),
    .ptr(ptr)
  );

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      nxt      <= PH_IDLE;
      cnt      <= '0;
      shift    <= '0;
      tx       <= '0;
      hi_q     <= '0;
      wrote    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      commit   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      commit   <= 1'b0;
      if (start_det) begin
        phase  <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        commit <= wrote;
        wrote  <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_HOLD) begin
        if (scl_rise) begin
          if (cnt == LAST_BIT) begin
            cnt <= '0;
            if (phase == PH_RDATA) phase <= sda_q ? PH_HOLD : PH_RDATA;
            else                   phase <= nxt;
          end else begin
            cnt   <= cnt + 1'b1;
            shift <= {shift[6:0], sda_q};
          end
        end else if (scl_fall) begin
          if (phase == PH_RDATA) begin
            if (cnt == '0) begin
              sda_oe <= ~rd_data[7];
              tx     <= {rd_data[6:0], 1'b0};
            end else if (cnt < LAST_BIT) begin
              sda_oe <= ~tx[7];
              tx     <= {tx[6:0], 1'b0};
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (cnt == LAST_BIT) begin
            case (phase)
              PH_DEV: begin
                if (dev_match) begin
                  sda_oe <= 1'b1;
                  nxt    <= shift[0] ? PH_RDATA : PH_AHI;
                end else begin
                  phase <= PH_HOLD;
                end
              end
              PH_AHI: begin
                sda_oe <= 1'b1;
                hi_q   <= shift[HI_W-1:0];
                nxt    <= PH_ALO;
              end
              PH_ALO: begin
                sda_oe <= 1'b1;
                nxt    <= PH_WDATA;
              end
              PH_WDATA: begin
                if (wr_ready) begin
                  sda_oe   <= 1'b1;
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= shift;
                  wrote    <= 1'b1;
                  nxt      <= PH_WDATA;
                end else begin
                  phase <= PH_HOLD;
                end
              end
              default: phase <= PH_HOLD;
            endcase
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic wr_valid,
  input logic wr_ready,
  input logic commit,
  input logic scl_q,
  input logic stop_det
);
  // R5: a write beat is only issued when the controller was ready
  a_r5_beat_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(wr_ready));
  // R5: each beat lasts a single cycle
  a_r5_beat_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R7: commit only follows a detected STOP
  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det));
  // R7: commit is a single-cycle pulse
  a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R11: the drive enable moves only while the synchronised clock is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_q);
endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .commit(commit), .scl_q(scl_q), .stop_det(stop_det)
);

// File: tb/eep_i2c_target_test.sv
module eep_i2c_target_test;
  localparam int Q = 10;
  localparam int AW = 13;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_w;
  logic busy = 1'b0, wr_ready = 1'b1;
  logic wr_valid, commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0] mem [0:8191];
  logic [7:0] exp_mem [0:8191];
  int wr_cnt = 0, commit_cnt = 0;
  logic [AW-1:0] last_wa;
  logic [7:0] last_wd;
  logic [AW-1:0] m_ptr = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_w   = m_sda & ~sda_oe;
  assign rd_data = mem[rd_addr];

  eep_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      mem[wr_addr] <= wr_data;
      last_wa <= wr_addr;
      last_wd <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
  end

  function automatic logic [AW-1:0] next_in_page(logic [AW-1:0] a);
    return {a[AW-1:5], a[4:0] + 5'd1};
  endfunction
  function automatic logic [AW-1:0] next_full(logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask
  task automatic recv_bit(output bit b);
    m_sda = 1; tick(Q); scl = 1; tick(Q); b = sda_w; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bus_start;
    m_sda = 1; tick(Q); scl = 1; tick(Q); m_sda = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bus_stop;
    m_sda = 0; tick(Q); scl = 1; tick(Q); m_sda = 1; tick(2*Q);
  endtask
  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(x);
    ack = !x;
  endtask
  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    bit x;
    for (int i = 0; i < 8; i++) begin recv_bit(x); d = {d[6:0], x}; end
    send_bit(!give_ack);
  endtask

  // Set the pointer with a dummy write; leaves the bus held after the low byte.
  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    bit ack;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack); check(ack, "R2 device ack", ack, 1);
    write_byte(hi, ack); check(ack, "R4 high addr ack", ack, 1);
    write_byte(lo, ack); check(ack, "R4 low addr ack", ack, 1);
    m_ptr = {hi[4:0], lo};
  endtask

  task automatic write_burst(input logic [AW-1:0] a, input int n);
    bit ack;
    logic [7:0] d;
    int c0;
    c0 = commit_cnt;
    set_addr({3'b000, a[12:8]}, a[7:0]);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      write_byte(d, ack);
      check(ack, "R5 data ack", ack, 1);
      check(last_wa == m_ptr, "R6 beat address", last_wa, m_ptr);
      check(last_wd == d, "R5 beat data", last_wd, d);
      exp_mem[m_ptr] = d;
      m_ptr = next_in_page(m_ptr);
    end
    bus_stop();
    check(commit_cnt == c0 + 1, "R7 commit after STOP", commit_cnt, c0 + 1);
  endtask

  // Read n bytes from the current pointer (read device byte issued here).
  task automatic read_run(input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b1}, ack); check(ack, "R2 read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      check(d == exp_mem[m_ptr], tag, d, exp_mem[m_ptr]);
      m_ptr = next_full(m_ptr);
    end
    check(sda_oe == 0, "R9 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    int w0, c0;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    tick(5); rst_n = 1; tick(5);
    check(sda_oe == 0 && wr_valid == 0 && commit == 0, "R11 reset outputs", sda_oe, 0);
    check(rd_addr == 0, "R11 reset pointer", rd_addr, 0);

    read_run(2, "R10 current read after reset");

    // R3: busy blocks the device ACK, released once busy drops
    busy = 1;
    bus_start(); write_byte({4'b1010, STRAP, 1'b0}, ack); bus_stop();
    check(!ack, "R3 NACK while busy", ack, 0);
    busy = 0;
    bus_start(); write_byte({4'b1010, STRAP, 1'b0}, ack); bus_stop();
    check(ack, "R3 ACK once idle", ack, 1);

    // R2: wrong strap bits, following bytes ignored
    w0 = wr_cnt;
    bus_start(); write_byte({4'b1010, 3'b011, 1'b0}, ack);
    check(!ack, "R2 mismatch NACK", ack, 0);
    write_byte(8'h00, ack); check(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();
    check(wr_cnt == w0, "R2 no beat on mismatch", wr_cnt, w0);

    // R7: dummy write gives no commit
    c0 = commit_cnt;
    set_addr(8'h00, 8'h40); bus_stop();
    check(commit_cnt == c0, "R7 no commit on dummy write", commit_cnt, c0);

    // R6: page wrap inside the 32-byte page, then R10 current read
    write_burst(13'h005E, 3);
    check(m_ptr == 13'h0041, "R6 pointer wrapped in page", m_ptr, 13'h0041);
    read_run(1, "R10 current read after page write");

    // R5: back-pressure gives NACK and no beat
    w0 = wr_cnt; c0 = commit_cnt;
    wr_ready = 0;
    set_addr(8'h01, 8'h20);
    write_byte(8'hA5, ack); check(!ack, "R5 NACK when not ready", ack, 0);
    wr_ready = 1;
    write_byte(8'h5A, ack); check(!ack, "R5 rest ignored", ack, 0);
    bus_stop();
    check(wr_cnt == w0, "R5 no beat when not ready", wr_cnt, w0);
    check(commit_cnt == c0, "R5 no commit when refused", commit_cnt, c0);
    read_run(1, "R5 location unchanged");

    // R1: STOP in the middle of a byte
    w0 = wr_cnt;
    set_addr(8'h00, 8'h10);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check(wr_cnt == w0, "R1 STOP mid-byte no beat", wr_cnt, w0);
    check(sda_oe == 0, "R1 idle after STOP", sda_oe, 0);
    // R1: repeated START mid data byte, then R8 random read
    set_addr(8'h00, 8'h90);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    read_run(2, "R8 random read after abort");
    check(wr_cnt == w0, "R1 START mid-byte no beat", wr_cnt, w0);

    // R4 + R9: upper high bits ignored, sequential wrap 8191 -> 0
    set_addr(8'hFF, 8'hFE);
    check(m_ptr == 13'h1FFE, "R4 upper bits dropped", m_ptr, 13'h1FFE);
    read_run(4, "R9 sequential wrap");
    read_run(1, "R9 current read after wrap");
    // R9: NACK exactly on 8191
    set_addr(8'h1F, 8'hFF);
    read_run(1, "R9 read at top");
    check(m_ptr == 0, "R9 pointer model wrapped", m_ptr, 0);
    read_run(1, "R9 current read after NACK at top");

    // Random rounds: write a burst, read back the whole page
    for (int r = 0; r < 6; r++) begin
      a = 13'($urandom);
      write_burst(a, 1 + int'($urandom % 6));
      set_addr({3'b000, a[12:8]}, {a[7:5], 5'd0});
      read_run(32, "R8 random page readback");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule